// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises one byte at a time into an asynchronous serial frame. A write strobe places a byte in a single-entry holding register. As soon as the shift engine is idle the byte moves into it, and the engine sends the frame on the serial line. Each bit lasts sixteen pulses of a 16x baud tick supplied from outside the block.

A seven-bit format input sets the character layout. It selects 5 to 8 data bits, one or extended stop bits, optional parity (even, odd or stick), and a break override. The break override holds the line low without disturbing the engine underneath.

Two status outputs tell the producer what state the block is in. The holding-empty flag means another byte may be written. The transmitter-empty flag means the line has gone fully quiet.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is off, `txd` is high, and both `hold_empty` and `tx_empty` are high.
- R2: A frame starts with one low start bit, followed by the data bits least significant bit first. Every full bit slot lasts exactly 16 `baud_tick` pulses.
- R3: `fmt_ctrl[1:0]` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of `wr_data` are not sent.
- R4: When `fmt_ctrl[2]` is 0, one stop bit (high) is sent. When it is 1, 1.5 stop bits (24 ticks) are sent for 5-bit characters and 2 stop bits for 6 to 8 bits. `tx_empty` rises right after the last stop tick.
- R5: When `fmt_ctrl[3]` is 1, a parity bit follows the last data bit. With `fmt_ctrl[4]`=1 the data plus parity hold an even number of ones; with `fmt_ctrl[4]`=0 they hold an odd number.
- R6: When `fmt_ctrl[3]`=1 and `fmt_ctrl[5]`=1, the parity bit is the inverse of `fmt_ctrl[4]`: 0 when even is selected and 1 when odd is selected.
- R7: While `fmt_ctrl[6]` is 1, `txd` is low. Frame timing and both status flags are unchanged by break.
- R8: `hold_empty` falls in the cycle after a write. It rises again one cycle later if the engine is idle, because the byte moves into the engine at that point. `tx_empty` is high only when the holding register is empty and the engine is idle.
- R9: A write while the holding register is full replaces the pending byte. Only the latest byte is sent.
- R10: A byte written while a frame is in progress waits in the holding register. It starts as its own frame right after the current frame ends, with `tx_empty` staying low in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Byte to transmit |
| fmt_ctrl | input | 7 | [1:0] length, [2] stop, [3] parity enable, [4] even, [5] stick, [6] break |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shift engine both idle |

## Verification
The bench targets the 1.5-stop case for 5-bit characters. A design that applied a full second stop slot there, or a half slot to longer characters, would raise `tx_empty` eight ticks late or early. Frames with stick parity under both even-select settings catch a design that computes ordinary parity or fails to invert the select bit. A break frame is checked for the same length and flag timing as a normal frame, which exposes a design that pauses or resets the engine instead of only masking the pin. Two writes during a running frame show whether a design queues both bytes, drops the newer one, or loses the gap between frames.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W    = 8;
  localparam int FRAME_W   = DATA_W + 2;            // start + data + parity
  localparam int MAX_SLOTS = FRAME_W + 2;           // plus up to two stop slots
  localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);

  // Layout of the format control byte; bit positions are part of the interface.
  typedef struct packed {
    logic       brk;     // [6] force line low
    logic       stick;   // [5] parity forced to ~even
    logic       even;    // [4] even parity select
    logic       par_en;  // [3] parity bit present
    logic       stop_x;  // [2] extended stop
    logic [1:0] len;     // [1:0] 5..8 data bits
  } tx_fmt_t;

  function automatic int unsigned data_len(logic [1:0] code);
    return 32'd5 + {30'd0, code};
  endfunction

  function automatic logic parity_of(logic [DATA_W-1:0] d, tx_fmt_t f);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(data_len(f.len))) acc = acc ^ d[i];
    end
    if (f.stick) return ~f.even;
    return f.even ? acc : ~acc;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_count(tx_fmt_t f);
    int n;
    n = 1 + int'(data_len(f.len)) + (f.par_en ? 1 : 0) + (f.stop_x ? 2 : 1);
    return SLOT_W'(n);
  endfunction

  function automatic logic half_stop(tx_fmt_t f);
    return f.stop_x && (f.len == 2'b00);
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(logic [DATA_W-1:0] d, tx_fmt_t f);
    logic [FRAME_W-1:0] fr;
    int n;
    n  = int'(data_len(f.len));
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) fr[i+1] = d[i];
    end
    if (f.par_en) fr[n+1] = parity_of(d, f);
    return fr;
  endfunction

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);

  logic [DATA_W-1:0] data_q;
  logic              full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (wr_en) begin
      // a new write always wins, even in the cycle the old byte is taken
      data_q <= wr_data;
      full_q <= 1'b1;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign hold_data = data_q;
  assign hold_full = full_q;

endmodule

// File: rtl/tx_shift_engine.sv
module tx_shift_engine
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  tx_fmt_t           load_fmt,
  output logic              line_bit,
  output logic              busy,
  output logic              slot_end,
  output logic              frame_end
);

  localparam int SUB_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int HALF  = OVERSAMPLE / 2;

  logic               busy_q;
  logic [FRAME_W-1:0] shreg_q;
  tx_fmt_t            fmt_q;
  logic [SUB_W-1:0]   sub_q;
  logic [SLOT_W-1:0]  slot_q;

  logic               last_slot;
  logic [SUB_W-1:0]   sub_limit;

  always_comb begin
    last_slot = (slot_q == slot_count(fmt_q) - SLOT_W'(1));
    if (last_slot && half_stop(fmt_q)) sub_limit = SUB_W'(HALF - 1);
    else                               sub_limit = SUB_W'(OVERSAMPLE - 1);
  end

  assign slot_end  = busy_q && tick && (sub_q == sub_limit);
  assign frame_end = slot_end && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      shreg_q <= '1;
      fmt_q   <= '0;
      sub_q   <= '0;
      slot_q  <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      shreg_q <= build_frame(load_data, load_fmt);
      fmt_q   <= load_fmt;
      sub_q   <= '0;
      slot_q  <= '0;
    end else if (busy_q && tick) begin
      if (slot_end) begin
        sub_q   <= '0;
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        slot_q  <= slot_q + SLOT_W'(1);
        if (last_slot) busy_q <= 1'b0;
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end

  assign line_bit = busy_q ? shreg_q[0] : 1'b1;
  assign busy     = busy_q;

endmodule

// File: rtl/tx_line_drive.sv
module tx_line_drive (
  input  logic line_bit,
  input  logic brk,
  output logic txd
);

  // break acts on the pin only; the engine keeps its own timing
  assign txd = brk ? 1'b0 : line_bit;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baud_tick,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic [6:0]  fmt_ctrl,
  output logic        txd,
  output logic        hold_empty,
  output logic        tx_empty
);

  tx_fmt_t           fmt_w;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              sh_busy;
  logic              load_evt;
  logic              slot_end;
  logic              frame_end;
  logic              line_bit;

  assign fmt_w    = tx_fmt_t'(fmt_ctrl);
  assign load_evt = hold_full && !sh_busy;

  tx_hold_reg u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (load_evt),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  tx_shift_engine #(.OVERSAMPLE(OVERSAMPLE)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .load      (load_evt),
    .load_data (hold_data),
    .load_fmt  (fmt_w),
    .line_bit  (line_bit),
    .busy      (sh_busy),
    .slot_end  (slot_end),
    .frame_end (frame_end)
  );

  tx_line_drive u_line (
    .line_bit (line_bit),
    .brk      (fmt_w.brk),
    .txd      (txd)
  );

  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && !sh_busy;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic brk,
  input logic busy,
  input logic load_evt,
  input logic frame_end,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty
);

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> txd); // R1

  AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (busy && !txd)); // R2

  AST_STOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !brk) |-> txd); // R4

  AST_FRAME_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy); // R4

  AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd); // R7

  AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty); // R8

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty); // R8

  AST_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_en) |=> hold_empty); // R8

  AST_QUEUED_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !hold_empty) |=> load_evt); // R10

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .brk        (fmt_ctrl[6]),
  .busy       (sh_busy),
  .load_evt   (load_evt),
  .frame_end  (frame_end),
  .txd        (txd),
  .hold_empty (hold_empty),
  .tx_empty   (tx_empty)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [6:0] fmt_ctrl;
  logic       txd, hold_empty, tx_empty;

  int n_checks = 0;
  int n_fail   = 0;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .fmt_ctrl(fmt_ctrl), .txd(txd),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    baud_tick = 1'b0;
    forever @(posedge clk) baud_tick <= ~baud_tick;
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    wr_data = b;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Expected frame: slot levels and total tick count, from the requirements.
  task automatic expect_frame(input logic [7:0] d, input logic [6:0] f,
                              output logic [11:0] lv, output int nticks);
    int nb, ones, ns;
    logic p;
    nb = 5 + int'(f[1:0]);
    ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    if (f[5])      p = ~f[4];
    else if (f[4]) p = (ones % 2 == 1);
    else           p = (ones % 2 == 0);
    lv = '1;
    lv[0] = 1'b0;
    for (int i = 0; i < nb; i++) lv[1+i] = d[i];
    ns = 1 + nb;
    if (f[3]) begin lv[ns] = p; ns++; end
    ns += f[2] ? 2 : 1;
    nticks = 16 * ns - ((f[2] && nb == 5) ? 8 : 0);
  endtask

  // Waits until the byte is in the engine, then samples txd on every tick.
  task automatic capture(input logic [7:0] d, input logic [6:0] f, input string req);
    logic [11:0] lv;
    int nticks, k, bad, first_k, first_act, first_exp, guard;
    logic early, e;
    expect_frame(d, f, lv, nticks);
    guard = 0;
    while (!hold_empty && guard < 2000) begin @(negedge clk); guard++; end
    k = 0; bad = 0; early = 1'b0; first_k = -1; first_act = 0; first_exp = 0;
    while (k < nticks) begin
      if (tx_empty) early = 1'b1;
      if (baud_tick) begin
        e = f[6] ? 1'b0 : lv[k/16];
        if (txd !== e) begin
          if (bad == 0) begin first_k = k; first_act = int'(txd); first_exp = int'(e); end
          bad++;
        end
        k++;
      end
      if (k < nticks) @(negedge clk);
    end
    check(bad == 0, req, $sformatf("line level at tick %0d", first_k), first_act, first_exp);
    check(!early, req, "tx_empty high before last tick", int'(early), 0);
  endtask

  task automatic expect_idle_after(input string req);
    @(negedge clk);
    check(tx_empty === 1'b1, req, "tx_empty after last stop tick", int'(tx_empty), 1);
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [6:0] f, input string req);
    fmt_ctrl = f;
    put_byte(d);
    capture(d, f, req);
    expect_idle_after(req);
  endtask

  task automatic t_reset;
    check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
    check(hold_empty === 1'b1, "R1", "hold_empty after reset", int'(hold_empty), 1);
    check(tx_empty === 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
  endtask

  task automatic t_flags;
    fmt_ctrl = 7'b0000011;
    put_byte(8'h3C);
    check(hold_empty === 1'b0, "R8", "hold_empty after write", int'(hold_empty), 0);
    check(tx_empty === 1'b0, "R8", "tx_empty after write", int'(tx_empty), 0);
    @(negedge clk);
    check(hold_empty === 1'b1, "R8", "hold_empty after move", int'(hold_empty), 1);
    check(tx_empty === 1'b0, "R8", "tx_empty while shifting", int'(tx_empty), 0);
    capture(8'h3C, fmt_ctrl, "R2");
    expect_idle_after("R8");
    check(txd === 1'b1, "R1", "txd idle after frame", int'(txd), 1);
  endtask

  task automatic t_lengths;
    run_frame(8'hA5, 7'b0000011, "R2");
    run_frame(8'hF3, 7'b0000000, "R3");
    run_frame(8'hE9, 7'b0000001, "R3");
    run_frame(8'h9B, 7'b0000010, "R3");
  endtask

  task automatic t_stops;
    run_frame(8'h15, 7'b0000100, "R4");
    run_frame(8'h2A, 7'b0000101, "R4");
    run_frame(8'h81, 7'b0000111, "R4");
  endtask

  task automatic t_parity;
    run_frame(8'h55, 7'b0011010, "R5");
    run_frame(8'h57, 7'b0011010, "R5");
    run_frame(8'h57, 7'b0001010, "R5");
    run_frame(8'hC1, 7'b0001000, "R5");
  endtask

  task automatic t_stick;
    run_frame(8'h01, 7'b0111011, "R6");
    run_frame(8'h03, 7'b0101011, "R6");
  endtask

  task automatic t_break;
    fmt_ctrl = 7'b1000000;
    @(negedge clk);
    check(txd === 1'b0, "R7", "txd with break while idle", int'(txd), 0);
    run_frame(8'hFF, 7'b1001111, "R7");
    fmt_ctrl = 7'b0000011;
    @(negedge clk);
    check(txd === 1'b1, "R7", "txd after break cleared", int'(txd), 1);
  endtask

  task automatic t_queue;
    int guard;
    fmt_ctrl = 7'b0000011;
    put_byte(8'h11);
    guard = 0;
    while (!hold_empty && guard < 100) begin @(negedge clk); guard++; end
    put_byte(8'h22);
    put_byte(8'h6E);
    check(hold_empty === 1'b0, "R10", "hold_empty while byte waits", int'(hold_empty), 0);
    check(tx_empty === 1'b0, "R10", "tx_empty while byte waits", int'(tx_empty), 0);
    guard = 0;
    while (hold_empty === 1'b0 && guard < 2000) begin
      if (tx_empty) begin
        check(1'b0, "R10", "tx_empty between queued frames", 1, 0);
        guard = 2000;
      end
      @(negedge clk);
      guard++;
    end
    capture(8'h6E, fmt_ctrl, "R9");
    expect_idle_after("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    fmt_ctrl = 7'b0000011;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flags();
    t_lengths();
    t_stops();
    t_parity();
    t_stick();
    t_break();
    t_queue();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule